// File: doc/BRIEF.md
# Register-Driven Atomic Read-Modify-Write Unit

This block gives a processor without load-linked or store-conditional instructions a way to update one memory word atomically. Software drives it through three registers on a small slave port. Writing a word address to the address register does two things: it fetches that word into the data register and it opens a reservation. Software then reads the data register and computes the new value itself. Writing that value back to the data register asks the block to store it to the reserved address.

While the reservation is open, the block watches four kinds of event. These are another master touching the reserved word, a taken interrupt, a loss of the bus lock, and an error response on the fetch or the store. Each kind has its own sticky flag in the status register. If any flag is set when the data write arrives, the store is dropped and never reaches memory. Software reads the status register after every attempt and retries the whole sequence when the status is nonzero. The master port holds a lock request from the address write until the store completes.

Top module: `atomic_rmw_unit`

## Requirements
- R1: After reset, status reads 0, no memory request is pending, the lock output is low and the slave port is ready.
- R2: A write of a word address to offset 0x0 issues exactly one memory read at that address. When the read is acknowledged without error, the returned word appears at offset 0x4. Offset 0x0 reads back the written address.
- R3: A write to offset 0x0 clears all four watch flags. This holds even if some were set before.
- R4: A write to offset 0x4 while a reservation is open and no flag is set issues one memory write of that value to the reserved address. The reservation then closes.
- R5: Status at offset 0x8 carries the read watch in bit 0, the bus-lock watch in bit 1, the interrupt watch in bit 2, the bus-error watch in bit 3 and busy in bit 4. All other bits read 0. Several flags can be set at once.
- R6: `snoop_valid` with `snoop_addr` equal to the reserved address, while the reservation is open, sets bit 0. A different address has no effect.
- R7: An `irq_taken` pulse while the reservation is open sets bit 2.
- R8: A `lock_lost` pulse while the reservation is open sets bit 1.
- R9: An error response on the fetch or on the store sets bit 3. An erroring store does not update memory.
- R10: A write to offset 0x4 when any flag is already set, or is being set in that same cycle, issues no memory write. It closes the reservation.
- R11: `s_ready` is low from the cycle after an accepted address write until the fetch is acknowledged. It is low likewise for an accepted store. Slave accesses wait while it is low.
- R12: A write to offset 0x4 with no open reservation writes no memory. It leaves the data register unchanged and sets bit 0.
- R13: `m_lock` is high from the address write until the store is acknowledged or the reservation closes. Watch events outside the reservation leave the flags unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| s_req | input | 1 | Slave access request |
| s_we | input | 1 | Slave access is a write |
| s_addr | input | OFS_W | Slave byte offset (0x0 address, 0x4 data, 0x8 status) |
| s_wdata | input | DW | Slave write data |
| s_ready | output | 1 | Access accepted this cycle when high with s_req |
| s_rdata | output | DW | Slave read data, valid with s_ready |
| m_req | output | 1 | Memory request, held until m_ack |
| m_we | output | 1 | Memory request is a write |
| m_addr | output | AW | Memory word address |
| m_wdata | output | DW | Memory write data |
| m_lock | output | 1 | Bus lock request over the reservation |
| m_ack | input | 1 | Memory response for the current request |
| m_err | input | 1 | Response is an error, valid with m_ack |
| m_rdata | input | DW | Memory read data, valid with m_ack |
| snoop_valid | input | 1 | Another master accesses snoop_addr this cycle |
| snoop_addr | input | AW | Address of the other master's access |
| irq_taken | input | 1 | Pulse: the processor took an interrupt |
| lock_lost | input | 1 | Pulse: the bus lock could not be held |

## Verification
A flag register that fails to capture an event shows up on the next status read as a zero where the bit should be set. The following data write then also reaches memory when it should have been dropped. A sequencer left in the wrong state shows on the very next clock as `s_ready` or `m_req` at the wrong level. A wrong held address or value shows as a mismatch on `m_addr` or `m_wdata` in the first cycle of the memory request. The reference model compares all of these every cycle, so a fault appears within one clock of its cause rather than only at the end of a sequence.

// File: rtl/arw_pkg.sv
`timescale 1ns/100ps
package arw_pkg;
    typedef enum logic [1:0] {
        SEQ_IDLE  = 2'd0,
        SEQ_FETCH = 2'd1,
        SEQ_STORE = 2'd2
    } seq_state_e;

    localparam int FLAG_N   = 4;
    localparam int BIT_RDW  = 0;
    localparam int BIT_LKW  = 1;
    localparam int BIT_IRW  = 2;
    localparam int BIT_BEW  = 3;

    localparam int SEL_ADDR = 0;
    localparam int SEL_DATA = 1;
    localparam int SEL_STAT = 2;
endpackage

// File: rtl/arw_watch.sv
`timescale 1ns/100ps
module arw_watch
    import arw_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_i,
    input  logic              rsv_i,
    input  logic              snoop_hit_i,
    input  logic              irq_i,
    input  logic              lock_lost_i,
    input  logic              fetch_err_i,
    input  logic              store_err_i,
    input  logic              stray_i,
    output logic [FLAG_N-1:0] flags_o,
    output logic              abort_o
);
    typedef struct packed {
        logic [FLAG_N-1:0] flags;
    } watch_s;

    watch_s q, d;
    logic [FLAG_N-1:0] ev_raw, ev_live, err_bits;

    always_comb begin
        ev_raw          = '0;
        ev_raw[BIT_RDW] = snoop_hit_i;
        ev_raw[BIT_LKW] = lock_lost_i;
        ev_raw[BIT_IRW] = irq_i;
        ev_live         = (rsv_i && !clr_i) ? ev_raw : '0;

        err_bits          = '0;
        err_bits[BIT_BEW] = fetch_err_i | store_err_i;
        err_bits[BIT_RDW] = stray_i;

        abort_o = |(q.flags | ev_live);

        d = q;
        if (clr_i) begin
            d.flags = '0;
        end else begin
            d.flags = q.flags | ev_live | err_bits;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{flags: '0};
        end else begin
            q <= d;
        end
    end

    assign flags_o = q.flags;

    // R3
    flags_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(clr_i) |-> (flags_o == '0));

    // R12
    stray_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stray_i |=> flags_o[BIT_RDW]);
endmodule

// File: rtl/arw_seq.sv
`timescale 1ns/100ps
module arw_seq
    import arw_pkg::*;
#(
    parameter int AW = 32,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_addr_i,
    input  logic          wr_data_i,
    input  logic [DW-1:0] wdata_i,
    input  logic          abort_i,
    input  logic          m_ack_i,
    input  logic          m_err_i,
    input  logic [DW-1:0] m_rdata_i,
    output logic [AW-1:0] addr_o,
    output logic [DW-1:0] data_o,
    output logic          rsv_o,
    output logic          busy_o,
    output logic          m_req_o,
    output logic          m_we_o,
    output logic [AW-1:0] m_addr_o,
    output logic [DW-1:0] m_wdata_o,
    output logic          m_lock_o,
    output logic          fetch_err_o,
    output logic          store_err_o,
    output logic          stray_o
);
    typedef struct packed {
        seq_state_e    st;
        logic          rsv;
        logic [AW-1:0] addr;
        logic [DW-1:0] data;
    } seq_s;

    seq_s q, d;

    always_comb begin
        d           = q;
        fetch_err_o = 1'b0;
        store_err_o = 1'b0;
        stray_o     = 1'b0;
        unique case (q.st)
            SEQ_IDLE: begin
                if (wr_addr_i) begin
                    d.addr = wdata_i[AW-1:0];
                    d.rsv  = 1'b1;
                    d.st   = SEQ_FETCH;
                end else if (wr_data_i) begin
                    if (q.rsv) begin
                        d.rsv  = 1'b0;
                        d.data = wdata_i;
                        if (!abort_i) d.st = SEQ_STORE;
                    end else begin
                        stray_o = 1'b1;
                    end
                end
            end
            SEQ_FETCH: begin
                if (m_ack_i) begin
                    d.st = SEQ_IDLE;
                    if (m_err_i) fetch_err_o = 1'b1;
                    else         d.data      = m_rdata_i;
                end
            end
            SEQ_STORE: begin
                if (m_ack_i) begin
                    d.st        = SEQ_IDLE;
                    store_err_o = m_err_i;
                end
            end
            default: d.st = SEQ_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{st: SEQ_IDLE, rsv: 1'b0, addr: '0, data: '0};
        end else begin
            q <= d;
        end
    end

    assign addr_o    = q.addr;
    assign data_o    = q.data;
    assign rsv_o     = q.rsv;
    assign busy_o    = (q.st != SEQ_IDLE);
    assign m_req_o   = (q.st != SEQ_IDLE);
    assign m_we_o    = (q.st == SEQ_STORE);
    assign m_addr_o  = q.addr;
    assign m_wdata_o = q.data;
    assign m_lock_o  = q.rsv || (q.st == SEQ_STORE);

    // R2
    fetch_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (m_req_o && !m_we_o && !$past(m_req_o)) |->
        ($past(wr_addr_i) && (m_addr_o == $past(wdata_i[AW-1:0]))));

    // R4
    store_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (m_req_o && m_we_o && !$past(m_req_o)) |->
        ($past(wr_data_i) && (m_wdata_o == $past(wdata_i))));

    // R13
    lock_span_chk: assert property (@(posedge clk) disable iff (!rst_n)
        m_req_o |-> m_lock_o);
endmodule

// File: rtl/atomic_rmw_unit.sv
`timescale 1ns/100ps
module atomic_rmw_unit
    import arw_pkg::*;
#(
    parameter int AW    = 32,
    parameter int DW    = 32,
    parameter int OFS_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             s_req,
    input  logic             s_we,
    input  logic [OFS_W-1:0] s_addr,
    input  logic [DW-1:0]    s_wdata,
    output logic             s_ready,
    output logic [DW-1:0]    s_rdata,
    output logic             m_req,
    output logic             m_we,
    output logic [AW-1:0]    m_addr,
    output logic [DW-1:0]    m_wdata,
    output logic             m_lock,
    input  logic             m_ack,
    input  logic             m_err,
    input  logic [DW-1:0]    m_rdata,
    input  logic             snoop_valid,
    input  logic [AW-1:0]    snoop_addr,
    input  logic             irq_taken,
    input  logic             lock_lost
);
    localparam int SELW = OFS_W - 2;

    logic [SELW-1:0]   sel;
    logic              aligned, acc, wr_addr, wr_data;
    logic [AW-1:0]     held_addr;
    logic [DW-1:0]     held_data;
    logic              rsv, busy, abort, snoop_hit;
    logic              fetch_err, store_err, stray;
    logic [FLAG_N-1:0] flags;

    assign sel       = s_addr[OFS_W-1:2];
    assign aligned   = (s_addr[1:0] == 2'b00);
    assign s_ready   = !busy;
    assign acc       = s_req && s_ready && aligned;
    assign wr_addr   = acc && s_we && (sel == SELW'(SEL_ADDR));
    assign wr_data   = acc && s_we && (sel == SELW'(SEL_DATA));
    assign snoop_hit = snoop_valid && (snoop_addr == held_addr);

    arw_seq #(.AW(AW), .DW(DW)) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_addr_i   (wr_addr),
        .wr_data_i   (wr_data),
        .wdata_i     (s_wdata),
        .abort_i     (abort),
        .m_ack_i     (m_ack),
        .m_err_i     (m_err),
        .m_rdata_i   (m_rdata),
        .addr_o      (held_addr),
        .data_o      (held_data),
        .rsv_o       (rsv),
        .busy_o      (busy),
        .m_req_o     (m_req),
        .m_we_o      (m_we),
        .m_addr_o    (m_addr),
        .m_wdata_o   (m_wdata),
        .m_lock_o    (m_lock),
        .fetch_err_o (fetch_err),
        .store_err_o (store_err),
        .stray_o     (stray)
    );

    arw_watch u_watch (
        .clk         (clk),
        .rst_n       (rst_n),
        .clr_i       (wr_addr),
        .rsv_i       (rsv),
        .snoop_hit_i (snoop_hit),
        .irq_i       (irq_taken),
        .lock_lost_i (lock_lost),
        .fetch_err_i (fetch_err),
        .store_err_i (store_err),
        .stray_i     (stray),
        .flags_o     (flags),
        .abort_o     (abort)
    );

    always_comb begin
        s_rdata = '0;
        if (aligned) begin
            if (sel == SELW'(SEL_ADDR))      s_rdata = DW'(held_addr);
            else if (sel == SELW'(SEL_DATA)) s_rdata = held_data;
            else if (sel == SELW'(SEL_STAT)) s_rdata = DW'({busy, flags});
        end
    end

    // R10
    abort_nostore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_data && rsv && abort) |=> !m_req);
endmodule

// File: tb/atomic_rmw_unit_test.sv
`timescale 1ns/100ps
module atomic_rmw_unit_test;
    localparam int AW = 32;
    localparam int DW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          s_req = 1'b0, s_we = 1'b0;
    logic [3:0]    s_addr = '0;
    logic [DW-1:0] s_wdata = '0;
    logic          s_ready;
    logic [DW-1:0] s_rdata;
    logic          m_req, m_we, m_lock;
    logic [AW-1:0] m_addr;
    logic [DW-1:0] m_wdata;
    logic          m_ack = 1'b0, m_err = 1'b0;
    logic [DW-1:0] m_rdata = '0;
    logic          snoop_valid = 1'b0;
    logic [AW-1:0] snoop_addr = '0;
    logic          irq_taken = 1'b0, lock_lost = 1'b0;

    atomic_rmw_unit #(.AW(AW), .DW(DW), .OFS_W(4)) uut (
        .clk(clk), .rst_n(rst_n), .s_req(s_req), .s_we(s_we), .s_addr(s_addr),
        .s_wdata(s_wdata), .s_ready(s_ready), .s_rdata(s_rdata), .m_req(m_req),
        .m_we(m_we), .m_addr(m_addr), .m_wdata(m_wdata), .m_lock(m_lock),
        .m_ack(m_ack), .m_err(m_err), .m_rdata(m_rdata), .snoop_valid(snoop_valid),
        .snoop_addr(snoop_addr), .irq_taken(irq_taken), .lock_lost(lock_lost)
    );

    always #2 clk = ~clk;

    int n_chk = 0;
    int n_bad = 0;

    task automatic check(input string req, input string what,
                         input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // memory and responder
    logic [DW-1:0] mem [16];
    int   lat = 1;
    logic inj_err = 1'b0;
    int   wcnt = 0;
    int   wr_count = 0;

    always @(negedge clk) begin
        if (m_req === 1'b1) begin
            if (wcnt >= lat) begin
                m_ack   = 1'b1;
                m_err   = inj_err;
                m_rdata = mem[m_addr[5:2]];
                wcnt    = 0;
            end else begin
                m_ack = 1'b0;
                m_err = 1'b0;
                wcnt++;
            end
        end else begin
            m_ack = 1'b0;
            m_err = 1'b0;
            wcnt  = 0;
        end
    end

    always @(posedge clk) begin
        if (rst_n && m_req && m_ack && m_we && !m_err) begin
            mem[m_addr[5:2]] = m_wdata;
            wr_count++;
        end
    end

    // behavioural reference model
    int            mst = 0;
    bit            mrsv = 1'b0;
    logic [AW-1:0] maddr = '0;
    logic [DW-1:0] mdata = '0;
    logic [3:0]    mflags = '0;
    bit            t_wa, t_wd;
    logic [3:0]    t_live, t_nf;
    int            n_mst;

    always @(posedge clk) begin
        if (!rst_n) begin
            mst = 0; mrsv = 1'b0; maddr = '0; mdata = '0; mflags = '0;
        end else begin
            t_wa = s_req && (mst == 0) && s_we && (s_addr == 4'h0);
            t_wd = s_req && (mst == 0) && s_we && (s_addr == 4'h4);
            t_live = '0;
            if (mrsv && !t_wa)
                t_live = {1'b0, irq_taken, lock_lost,
                          (snoop_valid && snoop_addr == maddr)};
            t_nf  = mflags | t_live;
            n_mst = mst;
            if (t_wa) begin
                t_nf = '0; maddr = s_wdata; mrsv = 1'b1; n_mst = 1;
            end else if (t_wd) begin
                if (mrsv) begin
                    mdata = s_wdata;
                    if (t_nf == 4'h0) n_mst = 2;
                    mrsv = 1'b0;
                end else begin
                    t_nf = t_nf | 4'h1;
                end
            end
            if (mst == 1 && m_ack) begin
                if (m_err) t_nf = t_nf | 4'h8;
                else       mdata = m_rdata;
                n_mst = 0;
            end
            if (mst == 2 && m_ack) begin
                if (m_err) t_nf = t_nf | 4'h8;
                n_mst = 0;
            end
            mflags = t_nf;
            mst    = n_mst;
        end
    end

    // per-cycle comparison
    always @(negedge clk) begin
        #1;
        if (rst_n) begin
            check("R11", "s_ready", DW'(s_ready), DW'(mst == 0));
            check("R2",  "m_req",   DW'(m_req),   DW'(mst != 0));
            check("R4",  "m_we",    DW'(m_we),    DW'(mst == 2));
            check("R13", "m_lock",  DW'(m_lock),  DW'(mrsv || mst == 2));
            if (mst != 0) check("R2", "m_addr", DW'(m_addr), DW'(maddr));
            if (mst == 2) check("R4", "m_wdata", m_wdata, mdata);
            if (s_req && mst == 0) begin
                if (s_addr == 4'h0)      check("R2", "rdata addr", s_rdata, DW'(maddr));
                else if (s_addr == 4'h4) check("R2", "rdata data", s_rdata, mdata);
                else if (s_addr == 4'h8) check("R5", "rdata status", s_rdata, DW'(mflags));
            end
        end
    end

    task automatic reg_access(input bit we, input logic [3:0] off,
                              input logic [DW-1:0] wd,
                              output logic [DW-1:0] rd, output int waits);
        waits = 0;
        @(negedge clk);
        s_req = 1'b1; s_we = we; s_addr = off; s_wdata = wd;
        #0.5;
        while (!s_ready) begin
            waits++;
            @(negedge clk);
            #0.5;
        end
        rd = s_rdata;
        @(posedge clk);
        #0.5;
        s_req = 1'b0; s_we = 1'b0;
    endtask

    task automatic reg_wr(input logic [3:0] off, input logic [DW-1:0] wd);
        logic [DW-1:0] rd; int w;
        reg_access(1'b1, off, wd, rd, w);
    endtask

    task automatic reg_rd(input logic [3:0] off, output logic [DW-1:0] rd);
        int w;
        reg_access(1'b0, off, '0, rd, w);
    endtask

    task automatic pulse(input bit sn, input logic [AW-1:0] sa, input bit iq, input bit ll);
        @(negedge clk);
        snoop_valid = sn; snoop_addr = sa; irq_taken = iq; lock_lost = ll;
        @(negedge clk);
        snoop_valid = 1'b0; irq_taken = 1'b0; lock_lost = 1'b0;
    endtask

    task automatic summary;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    endtask

    initial begin
        #400000;
        n_chk++; n_bad++;
        $display("FAIL watchdog run did not finish actual=hung expected=done");
        summary();
        $finish;
    end

    initial begin
        logic [DW-1:0] rv;
        int w;
        int wc0;
        for (int i = 0; i < 16; i++) mem[i] = 32'hA000_0000 + i;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        @(negedge clk); #0.5;
        check("R1", "s_ready", DW'(s_ready), 32'd1);
        check("R1", "m_req",   DW'(m_req),   32'd0);
        check("R1", "m_lock",  DW'(m_lock),  32'd0);
        reg_rd(4'h8, rv); check("R1", "status", rv, 32'h0);

        // R2 fetch into data register
        reg_wr(4'h0, 32'h8);
        reg_rd(4'h4, rv); check("R2", "fetched word", rv, 32'hA000_0002);
        reg_rd(4'h0, rv); check("R2", "address readback", rv, 32'h8);
        check("R13", "lock during reservation", DW'(m_lock), 32'd1);

        // R4 clean store
        reg_wr(4'h4, 32'hA000_0055);
        reg_rd(4'h8, rv); check("R4", "status after store", rv, 32'h0);
        check("R4", "memory updated", mem[2], 32'hA000_0055);
        check("R4", "one write", DW'(wr_count), 32'd1);
        check("R13", "lock released", DW'(m_lock), 32'd0);

        // R12 data write after completed store
        reg_wr(4'h4, 32'h1234);
        reg_rd(4'h8, rv); check("R12", "stray sets read watch", rv, 32'h1);
        reg_rd(4'h4, rv); check("R12", "data unchanged", rv, 32'hA000_0055);
        check("R12", "no write", DW'(wr_count), 32'd1);

        // R13 events outside reservation
        pulse(1'b1, 32'h8, 1'b1, 1'b1);
        reg_rd(4'h8, rv); check("R13", "flags unchanged outside window", rv, 32'h1);

        // R3 clear on address write
        reg_wr(4'h0, 32'h10);
        reg_rd(4'h8, rv); check("R3", "flags cleared", rv, 32'h0);

        // R6 snoop
        pulse(1'b1, 32'h14, 1'b0, 1'b0);
        reg_rd(4'h8, rv); check("R6", "other address ignored", rv, 32'h0);
        pulse(1'b1, 32'h10, 1'b0, 1'b0);
        reg_rd(4'h8, rv); check("R6", "matching snoop", rv, 32'h1);
        wc0 = wr_count;
        reg_wr(4'h4, 32'hBEEF);
        reg_rd(4'h8, rv); check("R10", "status kept", rv, 32'h1);
        check("R10", "no write issued", DW'(wr_count), DW'(wc0));
        check("R10", "memory unchanged", mem[4], 32'hA000_0004);

        // R7 interrupt
        reg_wr(4'h0, 32'h10);
        pulse(1'b0, '0, 1'b1, 1'b0);
        reg_rd(4'h8, rv); check("R7", "interrupt watch", rv, 32'h4);
        reg_wr(4'h4, 32'hBEEF);
        check("R10", "no write after irq", DW'(wr_count), DW'(wc0));

        // R8 lock lost
        reg_wr(4'h0, 32'h10);
        pulse(1'b0, '0, 1'b0, 1'b1);
        reg_rd(4'h8, rv); check("R8", "bus-lock watch", rv, 32'h2);

        // R9 fetch error
        inj_err = 1'b1;
        reg_wr(4'h0, 32'hC);
        reg_rd(4'h8, rv); check("R9", "fetch error", rv, 32'h8);
        inj_err = 1'b0;
        // R9 store error
        reg_wr(4'h0, 32'hC);
        reg_rd(4'h8, rv); check("R9", "clean fetch", rv, 32'h0);
        inj_err = 1'b1;
        reg_wr(4'h4, 32'h77);
        reg_rd(4'h8, rv); check("R9", "store error", rv, 32'h8);
        inj_err = 1'b0;
        check("R9", "memory not updated", mem[3], 32'hA000_0003);

        // R11 stall lengths
        lat = 5;
        reg_wr(4'h0, 32'h18);
        reg_access(1'b0, 4'h8, '0, rv, w);
        check("R11", "fetch stall cycles", DW'(w), 32'd6);
        check("R11", "status after stall", rv, 32'h0);
        lat = 1;
        reg_wr(4'h4, 32'h6666);
        reg_access(1'b0, 4'h8, '0, rv, w);
        check("R11", "store stall cycles", DW'(w), 32'd2);
        check("R4", "second store", mem[6], 32'h6666);

        // R5 several flags together
        reg_wr(4'h0, 32'h1C);
        pulse(1'b1, 32'h1C, 1'b1, 1'b1);
        reg_rd(4'h8, rv); check("R5", "combined flags layout", rv, 32'h7);

        repeat (4) @(negedge clk);
        summary();
        $finish;
    end
endmodule